// File: doc/BRIEF.md
# Serial Leading-Zero Detector

This block examines a binary integer that arrives one bit per clock on `serial_bit`, most significant bit first, and marks the first 0 of that integer. The output `zero_flag_n` is produced in the same cycle as the bit it describes, so it is a Mealy output.

The output is low for exactly one bit, the first 0 of the current integer, and high for every other bit. The bits before that zero are all ones, and any bit after it is ignored. The block keeps one bit of state, which records whether a zero has already been seen.

A one-cycle pulse on `word_done` ends the current integer. At the following clock edge the detector is ready for a new integer. The synchronous reset `rst` puts the detector in the same ready state.

Top module: `lead_zero_detect`

## Requirements
- R1: Once `rst` has been released, the detector is armed, and `zero_flag_n` equals `serial_bit` in the first cycle.
- R2: While every bit of the current integer so far has been 1, `zero_flag_n` is 1.
- R3: In the cycle that carries the first 0 of the current integer, `zero_flag_n` is 0 in that same cycle, with no register delay.
- R4: For every bit after the first 0 of the current integer, `zero_flag_n` is 1, whether that bit is 0 or 1.
- R5: When `word_done` is 1 at a rising clock edge, the detector is armed again for the next cycle. In that next cycle, `zero_flag_n` equals `serial_bit`.
- R6: `word_done` has no effect on `zero_flag_n` in its own cycle. During that cycle the output still depends only on the stored state and `serial_bit`: it is 1 if a zero was already seen, and otherwise it equals `serial_bit`.
- R7: The first 0 of an integer may arrive in the same cycle as `word_done`. In that case `zero_flag_n` is 0 in that cycle, and the next integer still starts armed.
- R8: `rst` is synchronous and active high, and it takes priority over every other input. It clears the stored state at the next edge, even when a zero has already been seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| serial_bit | input | 1 | Current bit of the integer, most significant first |
| word_done | input | 1 | One-cycle delimiter that ends the integer and re-arms the detector |
| zero_flag_n | output | 1 | Low only for the first 0 bit of the integer, in the same cycle |

## Verification
`zero_flag_n` is due in the same cycle as the `serial_bit` it describes. `word_done` and `rst` act only through the state register, so their effect appears one edge later.

The bench drives the inputs just after a falling edge and samples the output one nanosecond later, well before the next rising edge. It then advances its own one-bit model at that rising edge. This way, a same-cycle result is compared with the state from before the edge, and a re-arm or reset is compared in the cycle that follows.

Directed cases cover a zero arriving together with the delimiter, a delimiter that arrives after a zero, and a reset that arrives after a zero. These are mixed with long random runs.

// File: rtl/lzd_pkg.sv
package lzd_pkg;

    typedef enum logic [0:0] {
        LZD_ARMED = 1'b0,
        LZD_SPENT = 1'b1
    } lzd_state_e;

    typedef struct packed {
        logic data;
        logic delim;
    } lzd_in_t;

    localparam lzd_state_e LZD_INIT = LZD_ARMED;

    function automatic lzd_state_e lzd_advance(input lzd_state_e cur, input lzd_in_t in);
        if (in.delim)
            return LZD_INIT;
        if (cur == LZD_SPENT || !in.data)
            return LZD_SPENT;
        return LZD_ARMED;
    endfunction

    function automatic logic lzd_flag(input lzd_state_e cur, input logic data);
        return (cur == LZD_SPENT) | data;
    endfunction

endpackage

// File: rtl/lzd_next_state.sv
module lzd_next_state
    import lzd_pkg::*;
(
    input  lzd_state_e cur_state,
    input  lzd_in_t    sample,
    output lzd_state_e nxt_state
);
    always_comb nxt_state = lzd_advance(cur_state, sample);
endmodule

// File: rtl/lzd_state_reg.sv
module lzd_state_reg
    import lzd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  lzd_state_e nxt_state,
    output lzd_state_e cur_state
);
    always_ff @(posedge clk) begin
        if (rst) cur_state <= LZD_INIT;
        else     cur_state <= nxt_state;
    end
endmodule

// File: rtl/lzd_flag_out.sv
module lzd_flag_out
    import lzd_pkg::*;
(
    input  lzd_state_e cur_state,
    input  logic       data,
    output logic       flag_n
);
    always_comb flag_n = lzd_flag(cur_state, data);
endmodule

// File: rtl/lead_zero_detect.sv
module lead_zero_detect
    import lzd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic serial_bit,
    input  logic word_done,
    output logic zero_flag_n
);
    lzd_in_t    sample;
    lzd_state_e state_q;
    lzd_state_e state_d;

    always_comb begin
        sample.data  = serial_bit;
        sample.delim = word_done;
    end

    lzd_next_state u_next (
        .cur_state (state_q),
        .sample    (sample),
        .nxt_state (state_d)
    );

    lzd_state_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .nxt_state (state_d),
        .cur_state (state_q)
    );

    lzd_flag_out u_out (
        .cur_state (state_q),
        .data      (serial_bit),
        .flag_n    (zero_flag_n)
    );
endmodule

// File: rtl/lead_zero_detect_chk.sv
module lead_zero_detect_chk
    import lzd_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       serial_bit,
    input logic       word_done,
    input logic       zero_flag_n,
    input lzd_state_e state_q
);
    // R8: reset forces the armed state for the next cycle
    assert_reset_arms_R8: assert property (@(posedge clk)
        rst |=> (state_q == LZD_ARMED));

    // R2: armed state with a 1 bit keeps the flag high
    assert_ones_high_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == LZD_ARMED && serial_bit) |-> zero_flag_n);

    // R3: armed state with a 0 bit drops the flag in the same cycle
    assert_first_zero_low_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == LZD_ARMED && !serial_bit) |-> !zero_flag_n);

    // R4: after a low flag without a delimiter, the flag stays high
    assert_after_zero_high_R4: assert property (@(posedge clk) disable iff (rst)
        (!zero_flag_n && !word_done) |=> zero_flag_n);

    // R5: the cycle after a delimiter follows the data bit
    assert_rearm_R5: assert property (@(posedge clk) disable iff (rst)
        word_done |=> (zero_flag_n == serial_bit));

    // R6: once spent, the flag is high even in a delimiter cycle
    assert_delim_no_effect_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == LZD_SPENT) |-> zero_flag_n);
endmodule

bind lead_zero_detect lead_zero_detect_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .serial_bit  (serial_bit),
    .word_done   (word_done),
    .zero_flag_n (zero_flag_n),
    .state_q     (state_q)
);

// File: tb/lead_zero_detect_tb_top.sv
`timescale 1ns/1ps
module lead_zero_detect_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic serial_bit = 1'b0;
    logic word_done = 1'b0;
    logic zero_flag_n;

    int checks = 0;
    int errors = 0;
    bit spent  = 1'b0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    lead_zero_detect dut_i (
        .clk         (clk),
        .rst         (rst),
        .serial_bit  (serial_bit),
        .word_done   (word_done),
        .zero_flag_n (zero_flag_n)
    );

    function automatic bit exp_flag(bit s, bit x);
        return s | x;
    endfunction

    function automatic bit exp_next(bit s, bit r, bit x, bit y);
        if (r || y) return 1'b0;
        return s | !x;
    endfunction

    task automatic step(bit r, bit x, bit y, string req);
        bit e;
        @(negedge clk);
        rst = r; serial_bit = x; word_done = y;
        #1;
        if (!r) begin
            e = exp_flag(spent, x);
            checks++;
            if (zero_flag_n !== e) begin
                errors++;
                $display("FAIL %s: zero_flag_n=%b expected %b (x=%b y=%b)", req, zero_flag_n, e, x, y);
            end
        end
        @(posedge clk);
        spent = exp_next(spent, r, x, y);
    endtask

    function automatic string tag_for(bit s, bit x, bit y);
        if (y && s) return "R6";
        if (y && !x) return "R7";
        if (s) return "R4";
        return x ? "R2" : "R3";
    endfunction

    initial begin
        bit x, y, r;
        void'($urandom(32'd1234));
        step(1, 0, 0, "R8");
        step(1, 0, 0, "R8");
        // R1: armed straight after reset
        step(0, 0, 0, "R1");
        step(0, 1, 0, "R4");
        step(0, 0, 1, "R6");
        // R5: re-armed after delimiter
        step(0, 1, 0, "R5");
        step(0, 1, 0, "R2");
        step(0, 0, 0, "R3");
        step(0, 0, 0, "R4");
        step(0, 1, 1, "R6");
        // R7: zero together with delimiter
        step(0, 0, 1, "R7");
        step(0, 0, 0, "R7");
        // R8: reset after a zero clears the state
        step(0, 1, 0, "R4");
        step(1, 1, 0, "R8");
        step(0, 0, 0, "R8");
        for (int i = 0; i < 3000; i++) begin
            x = 1'($urandom_range(0, 3) != 0);
            y = ($urandom_range(0, 7) == 0);
            r = ($urandom_range(0, 63) == 0);
            step(r, x, y, tag_for(spent, x, y));
        end
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: finished=0 expected 1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule